// File: doc/BRIEF.md
# Major-Cycle Sequencer with Stretchable I/O Transfer Cycle

This block produces the four-tick timing of every major cycle of an 18-bit processor and, when the cycle is an I/O transfer, carries out the bus exchange with an external device. Ticks are numbered 0 to 3. The first two ticks form the read half and carry a read strobe. The last two ticks form the write half and carry a write strobe. A value read early in a cycle can therefore be written back before the same cycle ends.

The CPU tells the sequencer, at the boundary between two cycles, whether the next cycle is an I/O transfer. During such a cycle the device can slow the bus with an active-low stretch input. The stretch adds wait ticks after tick 0, which extends the read half, or after tick 2, which extends the write half. At the last read tick the sequencer captures two active-low command bits (skip and OR-into-AC) and the device's data word. Through the write half it reports the skip request and the merged word, and it drives the accumulator value to the device. The command bits are pulled up on the board, so a device that does not answer leaves both bits high and the instruction does nothing.

Top module: `majcyc_seq`

## Requirements
- R1: While `rst_n` is low and on the first cycle after reset: `tick` = 0, `io_cycle` = 0, and `skip_req`, `ac_or_en` and `ac_or_word` are all zero.
- R2: In a cycle that is not an I/O transfer, `tick` advances 0→1→2→3→0 on every clock edge, whatever the level of `dev_stretch_n`.
- R3: `rd_strobe` is high exactly in ticks 0 and 1. `wr_strobe` is high exactly in ticks 2 and 3. The two strobes are never high together.
- R4: An I/O cycle with `dev_stretch_n` high throughout lasts exactly 4 clocks. In general it lasts 4 + (stretched clocks in tick 0) + (stretched clocks in tick 2).
- R5: In an I/O cycle, each clock edge seen in tick 0 or tick 2 with `dev_stretch_n` = 0 leaves `tick` unchanged. Ticks 1 and 3 always advance.
- R6: `dev_skip_n`, `dev_ora_n` and `dev_rdata` are sampled on the edge that leaves tick 1 of an I/O cycle. The results show during ticks 2 and 3 as `skip_req` = !dev_skip_n and `ac_or_en` = !dev_ora_n. They are held even if the device inputs change. Both flags are 0 in ticks 0 and 1 and in every cycle that is not an I/O transfer.
- R7: If both command bits are sampled high (no device answering), `skip_req` = 0, `ac_or_en` = 0, and the word driven to the device is `acc_in` unchanged.
- R8: `dev_wdata` is zero outside the write half of an I/O cycle. In the write half it carries `acc_in` OR the sampled device data when `ac_or_en` = 1, and `acc_in` otherwise.
- R9: `ac_or_word` is `acc_in | dev_rdata` as sampled at the last read tick while `ac_or_en` = 1, and zero otherwise.
- R10: `iot_req` is sampled only on the edge that leaves tick 3, and sets `io_cycle` for the whole next cycle. Changes of `iot_req` at other times have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one tick per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| iot_req | input | 1 | Next major cycle is an I/O transfer |
| acc_in | input | 18 | Accumulator value from the CPU |
| dev_rdata | input | 18 | Data returned by the device in the read half |
| dev_skip_n | input | 1 | Active-low skip request from the device |
| dev_ora_n | input | 1 | Active-low OR-into-AC request from the device |
| dev_stretch_n | input | 1 | Active-low wait request from the device |
| tick | output | 2 | Current tick, 0 to 3 |
| io_cycle | output | 1 | Current major cycle is an I/O transfer |
| rd_strobe | output | 1 | Read half of the cycle |
| wr_strobe | output | 1 | Write half of the cycle |
| dev_wdata | output | 18 | Word presented to the device in the write half |
| skip_req | output | 1 | Skip the next instruction |
| ac_or_en | output | 1 | Load `ac_or_word` into AC |
| ac_or_word | output | 18 | Accumulator merged with device data |

## Verification
The bench sweeps both cycle kinds against zero to two wait clocks in each half and all four command-bit combinations. It counts the clocks each cycle takes. A sequencer that stretched in a non-transfer cycle, or in tick 1 or tick 3, would show a wrong tick number and a wrong cycle length. Until tick 1 the device drives the inverse of its real answer, and from tick 2 on it drives the inverse again. A design that sampled too early, or that followed the live inputs through the write half, would report inverted flags or inverted data. `iot_req` is toggled during each cycle to show that only the boundary value decides the cycle kind. The no-response case is checked to leave the accumulator word untouched.

// File: rtl/majcyc_pkg.sv
package majcyc_pkg;

  localparam int TICK_W = 2;
  typedef logic [TICK_W-1:0] tick_t;

  localparam tick_t TICK_FIRST = tick_t'(0);
  localparam tick_t TICK_RDLAST = tick_t'(1);
  localparam tick_t TICK_LAST = tick_t'(3);

  // Wait ticks may only be inserted after the first tick of either half.
  function automatic logic tick_stretchable(input tick_t t);
    return (t == tick_t'(0)) || (t == tick_t'(2));
  endfunction

  function automatic tick_t tick_next(input tick_t t, input logic hold);
    return hold ? t : tick_t'(t + tick_t'(1));
  endfunction

  function automatic logic tick_in_read_half(input tick_t t);
    return (t == tick_t'(0)) || (t == tick_t'(1));
  endfunction

endpackage

// File: rtl/majcyc_tick_gen.sv
module majcyc_tick_gen
  import majcyc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  iot_req,
  input  logic  stretch_n,
  output tick_t tick,
  output logic  io_cycle,
  output logic  hold_ev,
  output logic  cycle_end_ev
);

  tick_t tick_q;
  logic  io_q;

  assign hold_ev      = io_q && !stretch_n && tick_stretchable(tick_q);
  assign cycle_end_ev = (tick_q == TICK_LAST) && !hold_ev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_q <= TICK_FIRST;
      io_q   <= 1'b0;
    end else begin
      tick_q <= tick_next(tick_q, hold_ev);
      if (cycle_end_ev) begin
        io_q <= iot_req;
      end
    end
  end

  assign tick     = tick_q;
  assign io_cycle = io_q;

endmodule

// File: rtl/majcyc_strobe_dec.sv
module majcyc_strobe_dec
  import majcyc_pkg::*;
(
  input  tick_t tick,
  input  logic  io_cycle,
  output logic  rd_strobe,
  output logic  wr_strobe,
  output logic  io_wr_half,
  output logic  io_sample_ev
);

  always_comb begin
    rd_strobe    = tick_in_read_half(tick);
    wr_strobe    = !rd_strobe;
    io_wr_half   = io_cycle && wr_strobe;
    io_sample_ev = io_cycle && (tick == TICK_RDLAST);
  end

endmodule

// File: rtl/majcyc_iot_latch.sv
module majcyc_iot_latch #(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_ev,
  input  logic              clear_ev,
  input  logic              skip_n,
  input  logic              ora_n,
  input  logic [DATA_W-1:0] dev_word,
  input  logic [DATA_W-1:0] acc_word,
  output logic              skip_q,
  output logic              ora_q,
  output logic [DATA_W-1:0] merged_q
);

  function automatic logic [DATA_W-1:0] merge_word(
    input logic              en,
    input logic [DATA_W-1:0] a,
    input logic [DATA_W-1:0] d
  );
    return en ? (a | d) : '0;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      skip_q   <= 1'b0;
      ora_q    <= 1'b0;
      merged_q <= '0;
    end else if (sample_ev) begin
      skip_q   <= !skip_n;
      ora_q    <= !ora_n;
      merged_q <= merge_word(!ora_n, acc_word, dev_word);
    end else if (clear_ev) begin
      skip_q   <= 1'b0;
      ora_q    <= 1'b0;
      merged_q <= '0;
    end
  end

endmodule

// File: rtl/majcyc_seq.sv
module majcyc_seq
  import majcyc_pkg::*;
#(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iot_req,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [DATA_W-1:0] dev_rdata,
  input  logic              dev_skip_n,
  input  logic              dev_ora_n,
  input  logic              dev_stretch_n,
  output logic [1:0]        tick,
  output logic              io_cycle,
  output logic              rd_strobe,
  output logic              wr_strobe,
  output logic [DATA_W-1:0] dev_wdata,
  output logic              skip_req,
  output logic              ac_or_en,
  output logic [DATA_W-1:0] ac_or_word
);

  tick_t             tick_w;
  logic              hold_ev;
  logic              cycle_end_ev;
  logic              io_wr_half;
  logic              io_sample_ev;
  logic              skip_q;
  logic              ora_q;
  logic [DATA_W-1:0] merged_q;

  majcyc_tick_gen u_tick (
    .clk          (clk),
    .rst_n        (rst_n),
    .iot_req      (iot_req),
    .stretch_n    (dev_stretch_n),
    .tick         (tick_w),
    .io_cycle     (io_cycle),
    .hold_ev      (hold_ev),
    .cycle_end_ev (cycle_end_ev)
  );

  majcyc_strobe_dec u_dec (
    .tick         (tick_w),
    .io_cycle     (io_cycle),
    .rd_strobe    (rd_strobe),
    .wr_strobe    (wr_strobe),
    .io_wr_half   (io_wr_half),
    .io_sample_ev (io_sample_ev)
  );

  majcyc_iot_latch #(.DATA_W(DATA_W)) u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_ev (io_sample_ev),
    .clear_ev  (cycle_end_ev),
    .skip_n    (dev_skip_n),
    .ora_n     (dev_ora_n),
    .dev_word  (dev_rdata),
    .acc_word  (acc_in),
    .skip_q    (skip_q),
    .ora_q     (ora_q),
    .merged_q  (merged_q)
  );

  always_comb begin
    if (!io_wr_half) begin
      dev_wdata = '0;
    end else if (ora_q) begin
      dev_wdata = merged_q;
    end else begin
      dev_wdata = acc_in;
    end
  end

  assign tick       = tick_w;
  assign skip_req   = skip_q;
  assign ac_or_en   = ora_q;
  assign ac_or_word = merged_q;

endmodule

// File: rtl/majcyc_seq_chk.sv
module majcyc_seq_chk #(
  parameter int DATA_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        tick,
  input logic              io_cycle,
  input logic              rd_strobe,
  input logic              wr_strobe,
  input logic [DATA_W-1:0] dev_wdata,
  input logic              skip_req,
  input logic              ac_or_en,
  input logic [DATA_W-1:0] ac_or_word
);

  assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({rd_strobe, wr_strobe}));

  assert_rd_in_low_ticks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |-> (tick < 2'd2));

  assert_plain_no_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !io_cycle |=> (tick == 2'($past(tick) + 2'd1)));

  assert_tick1_never_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick == 2'd1) |=> (tick == 2'd2));

  assert_tick3_never_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick == 2'd3) |=> (tick == 2'd0));

  assert_flags_only_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick < 2'd2 || !io_cycle) |-> (!skip_req && !ac_or_en));

  assert_flags_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick == 2'd2) |=> ($stable(skip_req) && $stable(ac_or_en) && $stable(ac_or_word)));

  assert_word_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ac_or_en |-> (ac_or_word == '0));

  assert_wdata_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_cycle || rd_strobe) |-> (dev_wdata == '0));

  assert_kind_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tick != 2'd3) |=> $stable(io_cycle));

endmodule

bind majcyc_seq majcyc_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick),
  .io_cycle   (io_cycle),
  .rd_strobe  (rd_strobe),
  .wr_strobe  (wr_strobe),
  .dev_wdata  (dev_wdata),
  .skip_req   (skip_req),
  .ac_or_en   (ac_or_en),
  .ac_or_word (ac_or_word)
);

// File: tb/majcyc_seq_tb.sv
module majcyc_seq_tb;

  localparam int W = 18;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         iot_req = 1'b0;
  logic [W-1:0] acc_in = '0;
  logic [W-1:0] dev_rdata = '0;
  logic         dev_skip_n = 1'b1;
  logic         dev_ora_n = 1'b1;
  logic         dev_stretch_n = 1'b1;
  logic [1:0]   tick;
  logic         io_cycle;
  logic         rd_strobe;
  logic         wr_strobe;
  logic [W-1:0] dev_wdata;
  logic         skip_req;
  logic         ac_or_en;
  logic [W-1:0] ac_or_word;

  int checks = 0;
  int errors = 0;
  int clocks_in_cycle = 0;

  always #5 clk = ~clk;

  majcyc_seq #(.DATA_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .iot_req(iot_req), .acc_in(acc_in),
    .dev_rdata(dev_rdata), .dev_skip_n(dev_skip_n), .dev_ora_n(dev_ora_n),
    .dev_stretch_n(dev_stretch_n), .tick(tick), .io_cycle(io_cycle),
    .rd_strobe(rd_strobe), .wr_strobe(wr_strobe), .dev_wdata(dev_wdata),
    .skip_req(skip_req), .ac_or_en(ac_or_en), .ac_or_word(ac_or_word)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clk1();
    @(posedge clk);
    @(negedge clk);
    clocks_in_cycle++;
  endtask

  task automatic chk_half(input string req, input int t);
    chk(req, "tick", 32'(tick), 32'(t));
    chk("R3", "rd_strobe", 32'(rd_strobe), 32'(t < 2));
    chk("R3", "wr_strobe", 32'(wr_strobe), 32'(t >= 2));
  endtask

  // Entered with the DUT in tick 3 of the previous cycle.
  task automatic run_cycle(input bit io, input int s0, input int s2,
                           input bit skip_on, input bit ora_on,
                           input logic [W-1:0] ac, input logic [W-1:0] dd);
    logic [W-1:0] exp_word;
    clocks_in_cycle = 0;
    iot_req    = io;
    acc_in     = ac;
    dev_rdata  = ~dd;
    dev_skip_n = skip_on;
    dev_ora_n  = ora_on;
    clk1();
    chk("R10", "io_cycle at tick 0", 32'(io_cycle), 32'(io));
    chk_half("R3", 0);
    chk("R8", "wdata read half", 32'(dev_wdata), 32'd0);
    iot_req = ~io;
    if (!io) begin
      dev_stretch_n = (s0 == 0);
      for (int t = 1; t < 4; t++) begin
        clk1();
        chk_half("R2", t);
        chk("R6", "skip plain", 32'(skip_req), 32'd0);
        chk("R6", "ora plain", 32'(ac_or_en), 32'd0);
        chk("R8", "wdata plain", 32'(dev_wdata), 32'd0);
        chk("R10", "io_cycle plain", 32'(io_cycle), 32'd0);
      end
      chk("R2", "plain length", 32'(clocks_in_cycle), 32'd4);
    end else begin
      for (int k = 0; k < s0; k++) begin
        dev_stretch_n = 1'b0;
        clk1();
        chk_half("R5", 0);
        chk("R6", "skip early", 32'(skip_req), 32'd0);
      end
      dev_stretch_n = 1'b1;
      clk1();
      chk_half("R4", 1);
      chk("R6", "ora tick1", 32'(ac_or_en), 32'd0);
      dev_rdata     = dd;
      dev_skip_n    = !skip_on;
      dev_ora_n     = !ora_on;
      dev_stretch_n = (s2 == 0);
      clk1();
      chk_half("R5", 2);
      exp_word = ora_on ? (ac | dd) : '0;
      chk("R6", "skip_req", 32'(skip_req), 32'(skip_on));
      chk("R6", "ac_or_en", 32'(ac_or_en), 32'(ora_on));
      chk("R9", "ac_or_word", 32'(ac_or_word), 32'(exp_word));
      chk("R8", "wdata", 32'(dev_wdata), 32'(ora_on ? (ac | dd) : ac));
      if (!skip_on && !ora_on) begin
        chk("R7", "no device wdata", 32'(dev_wdata), 32'(ac));
        chk("R7", "no device flags", 32'({skip_req, ac_or_en}), 32'd0);
      end
      dev_rdata  = dd ^ {W{1'b1}};
      dev_skip_n = skip_on;
      dev_ora_n  = ora_on;
      for (int k = 0; k < s2; k++) begin
        dev_stretch_n = 1'b0;
        clk1();
        chk_half("R5", 2);
        chk("R6", "skip held", 32'(skip_req), 32'(skip_on));
      end
      dev_stretch_n = 1'b1;
      clk1();
      chk_half("R4", 3);
      chk("R6", "ora held", 32'(ac_or_en), 32'(ora_on));
      chk("R9", "word held", 32'(ac_or_word), 32'(exp_word));
      chk("R10", "io_cycle held", 32'(io_cycle), 32'd1);
      chk("R4", "io length", 32'(clocks_in_cycle), 32'(4 + s0 + s2));
      dev_stretch_n = (s2 == 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R1", "tick in reset", 32'(tick), 32'd0);
    chk("R1", "io_cycle in reset", 32'(io_cycle), 32'd0);
    rst_n = 1'b1;
    chk("R1", "flags after reset", 32'({skip_req, ac_or_en}), 32'd0);
    chk("R1", "word after reset", 32'(ac_or_word), 32'd0);
    iot_req = 1'b1;
    for (int t = 1; t < 4; t++) begin
      clk1();
      chk_half("R2", t);
      chk("R10", "first cycle kind", 32'(io_cycle), 32'd0);
    end
    n = 0;
    for (int io = 0; io < 2; io++)
      for (int s0 = 0; s0 < 3; s0++)
        for (int s2 = 0; s2 < 3; s2++)
          for (int cmd = 0; cmd < 4; cmd++) begin
            run_cycle(io[0], s0, s2, cmd[0], cmd[1],
                      W'(32'h1_2345 * (n + 1)), W'(32'h0_9A3C ^ (n << 3)));
            n++;
          end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule